// File: doc/BRIEF.md
# Serial PSRAM identification probe

This block brings up an external serial PSRAM from its pins. A one-cycle start pulse launches a fixed sequence of chip-select frames. The first frame forces a device that is still in four-line mode back to single-line mode. The second frame reads the identification bytes. The block then checks the die byte and decodes the capacity from the extended ID byte. When a valid device is found, a last frame switches it into four-line command mode.

The block drives the serial clock, the active-low chip select and the four data lines. Each data line has its own output enable. The serial clock runs at the system clock divided by a divisor input. When the probe ends, the block raises a one-cycle done strobe. It also reports whether a device is present and a capacity code equal to the size in MiB. Memory-mapped reads and writes are handled elsewhere.

Top module: `psram_probe`

## Requirements
- R1: After reset, cs_no is 1, sck_o is 0, io_oe_o is 0, and done_o, present_o and size_o are all 0.
- R2: The first frame after start sends command 0xF5 in four-line mode. The high nibble goes out first on io_o[3:0], all four enables are set, and the frame lasts exactly 2 serial clock periods. Any read data is discarded.
- R3: The second frame is one chip-select assertion of 7 bytes: 0x9F, then six 0xFF bytes. Each byte is sent MSB first on io_o[0] alone (io_oe_o = 4'b0001), for 56 serial clocks in total.
- R4: Read data is sampled from io_i[1] at each rising serial clock edge. Byte index 5 of the ID frame is the die byte and byte index 6 is the extended ID byte. All other received bytes have no effect on the result.
- R5: present_o is 1 only when the die byte equals 0x5D. When present_o is 0, size_o is 0.
- R6: size_o gives the capacity in MiB. It is 8 when the extended ID byte is 0x26 or its bits [7:5] equal 2. It is 2 when bits [7:5] equal 0, 4 when they equal 1, and 1 for any other value.
- R7: When a device is present, a third frame sends the single-line byte 0x35. When no device is found, no third frame is issued.
- R8: The serial clock idles low. Its period is the effective divisor in system cycles, and its high phase lasts divisor/2 cycles, rounded down. The effective divisor is 30 when clk_div_i is 0, 2 when clk_div_i is 1, and clk_div_i otherwise.
- R9: Between frames, chip select stays high for at least twice the effective divisor in system cycles. While chip select is high, every output enable is 0 and the serial clock is low.
- R10: done_o pulses for exactly one cycle after the last frame closes. present_o and size_o are valid in that cycle and hold until the next accepted start.
- R11: A start pulse that arrives while a probe is running is ignored. The sequence, frame count and single done pulse are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle request to run the probe |
| clk_div_i | input | DIV_W | Serial clock divisor (0 selects the default) |
| io_i | input | 4 | Data lines sampled from the device |
| sck_o | output | 1 | Serial clock |
| cs_no | output | 1 | Chip select, active low |
| io_o | output | 4 | Data lines driven to the device |
| io_oe_o | output | 4 | Per-line output enables |
| done_o | output | 1 | One-cycle completion strobe |
| present_o | output | 1 | Device detected |
| size_o | output | 4 | Capacity in MiB (0 when absent) |

## Verification
The assertions assume that clk_div_i stays constant for the whole probe and that start_i is a synchronous pulse. The bench changes the divisor only between probes, after done_o. It sends start as single-cycle pulses, including one during a running probe. A behavioural device model answers on io_i[1]. It changes its data only on falling serial clock edges, so the data is stable at every rising edge where the block samples it.

// File: rtl/psram_probe_pkg.sv
package psram_probe_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEL,
    ST_XFER,
    ST_GAP,
    ST_FIN
  } seq_st_e;

  typedef enum logic [1:0] {
    TXN_EXIT,
    TXN_ID,
    TXN_QPI
  } txn_e;

  localparam logic [7:0] CMD_EXIT = 8'hF5;
  localparam logic [7:0] CMD_ID   = 8'h9F;
  localparam logic [7:0] CMD_FILL = 8'hFF;
  localparam logic [7:0] CMD_QPI  = 8'h35;
  localparam logic [7:0] DIE_OK   = 8'h5D;
  localparam logic [7:0] EID_8M   = 8'h26;

  localparam int unsigned ID_LAST = 6;
  localparam int unsigned DIE_IDX = 5;
  localparam int unsigned EID_IDX = 6;

endpackage

// File: rtl/psram_id_decode.sv
module psram_id_decode
  import psram_probe_pkg::*;
(
  input  logic [7:0] die_i,
  input  logic [7:0] eid_i,
  output logic       present_o,
  output logic [3:0] size_o
);

  logic [2:0] dens;
  logic [3:0] raw;

  assign dens      = eid_i[7:5];
  assign present_o = (die_i == DIE_OK);

  always_comb begin
    if (eid_i == EID_8M || dens == 3'd2) raw = 4'd8;
    else if (dens == 3'd0)               raw = 4'd2;
    else if (dens == 3'd1)               raw = 4'd4;
    else                                 raw = 4'd1;
  end

  assign size_o = present_o ? raw : 4'd0;

endmodule

// File: rtl/psram_byte_shift.sv
module psram_byte_shift #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  input  logic             go_i,
  input  logic             quad_i,
  input  logic [7:0]       tx_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [7:0]       rx_o,
  output logic             sck_o,
  output logic [3:0]       io_o,
  output logic [3:0]       io_oe_o,
  input  logic [3:0]       io_i
);

  logic             busy_q, quad_q, sck_q, done_q;
  logic [DIV_W-1:0] cnt_q;
  logic [2:0]       bit_q;
  logic [7:0]       sh_q, rx_q;
  logic [DIV_W-1:0] lo_len, rise_at, fall_at;
  logic             last_bit;

  assign lo_len   = div_i - (div_i >> 1);
  assign rise_at  = lo_len - 1'b1;
  assign fall_at  = div_i - 1'b1;
  assign last_bit = quad_q ? (bit_q == 3'd1) : (bit_q == 3'd7);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      quad_q <= 1'b0;
      sck_q  <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      bit_q  <= '0;
      sh_q   <= '0;
      rx_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (go_i) begin
          busy_q <= 1'b1;
          quad_q <= quad_i;
          sh_q   <= tx_i;
          cnt_q  <= '0;
          bit_q  <= '0;
          sck_q  <= 1'b0;
        end
      end else if (cnt_q == fall_at) begin
        cnt_q <= '0;
        sck_q <= 1'b0;
        if (last_bit) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          bit_q <= bit_q + 3'd1;
          sh_q  <= quad_q ? {sh_q[3:0], 4'h0} : {sh_q[6:0], 1'b0};
        end
      end else begin
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == rise_at) begin
          sck_q <= 1'b1;
          rx_q  <= quad_q ? {rx_q[3:0], io_i} : {rx_q[6:0], io_i[1]};
        end
      end
    end
  end

  assign busy_o  = busy_q;
  assign done_o  = done_q;
  assign rx_o    = rx_q;
  assign sck_o   = sck_q;
  assign io_o    = !busy_q ? 4'h0 : (quad_q ? sh_q[7:4] : {3'b000, sh_q[7]});
  assign io_oe_o = !busy_q ? 4'h0 : (quad_q ? 4'hF : 4'h1);

  // R8
  go_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_i |-> !busy_q);
  // R8
  sck_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |=> !sck_q);

endmodule

// File: rtl/psram_probe.sv
module psram_probe
  import psram_probe_pkg::*;
#(
  parameter int unsigned DIV_W   = 8,
  parameter int unsigned DEF_DIV = 30
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [DIV_W-1:0] clk_div_i,
  input  logic [3:0]       io_i,
  output logic             sck_o,
  output logic             cs_no,
  output logic [3:0]       io_o,
  output logic [3:0]       io_oe_o,
  output logic             done_o,
  output logic             present_o,
  output logic [3:0]       size_o
);

  localparam int unsigned GAP_W = DIV_W + 1;

  seq_st_e          st_q;
  txn_e             txn_q;
  logic [2:0]       byte_q;
  logic [GAP_W-1:0] gap_q;
  logic             cs_n_q, present_q;
  logic [3:0]       size_q;
  logic [7:0]       die_q, eid_q;
  logic [DIV_W-1:0] eff_div;
  logic [GAP_W-1:0] gap_load;
  logic             go, quad, sh_busy, sh_done, dec_present;
  logic [7:0]       tx_byte, rx_byte;
  logic [3:0]       dec_size;

  always_comb begin
    if (clk_div_i == '0)      eff_div = DIV_W'(DEF_DIV);
    else if (clk_div_i == 1)  eff_div = DIV_W'(2);
    else                      eff_div = clk_div_i;
  end

  assign gap_load = {eff_div, 1'b0} - 1'b1;

  always_comb begin
    unique case (txn_q)
      TXN_EXIT: tx_byte = CMD_EXIT;
      TXN_ID:   tx_byte = (byte_q == 3'd0) ? CMD_ID : CMD_FILL;
      default:  tx_byte = CMD_QPI;
    endcase
  end

  assign go   = (st_q == ST_SEL);
  assign quad = (txn_q == TXN_EXIT);

  psram_byte_shift #(.DIV_W(DIV_W)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .div_i   (eff_div),
    .go_i    (go),
    .quad_i  (quad),
    .tx_i    (tx_byte),
    .busy_o  (sh_busy),
    .done_o  (sh_done),
    .rx_o    (rx_byte),
    .sck_o   (sck_o),
    .io_o    (io_o),
    .io_oe_o (io_oe_o),
    .io_i    (io_i)
  );

  psram_id_decode u_decode (
    .die_i     (die_q),
    .eid_i     (eid_q),
    .present_o (dec_present),
    .size_o    (dec_size)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      txn_q     <= TXN_EXIT;
      byte_q    <= '0;
      gap_q     <= '0;
      cs_n_q    <= 1'b1;
      present_q <= 1'b0;
      size_q    <= '0;
      die_q     <= '0;
      eid_q     <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          present_q <= 1'b0;
          size_q    <= '0;
          die_q     <= '0;
          eid_q     <= '0;
          txn_q     <= TXN_EXIT;
          byte_q    <= '0;
          cs_n_q    <= 1'b0;
          st_q      <= ST_SEL;
        end
        ST_SEL: st_q <= ST_XFER;
        ST_XFER: if (sh_done) begin
          if (txn_q == TXN_ID && byte_q == 3'(DIE_IDX)) die_q <= rx_byte;
          if (txn_q == TXN_ID && byte_q == 3'(EID_IDX)) eid_q <= rx_byte;
          if (txn_q == TXN_ID && byte_q != 3'(ID_LAST)) begin
            byte_q <= byte_q + 3'd1;
            st_q   <= ST_SEL;
          end else begin
            cs_n_q <= 1'b1;
            byte_q <= '0;
            gap_q  <= gap_load;
            if (txn_q == TXN_EXIT) begin
              txn_q <= TXN_ID;
              st_q  <= ST_GAP;
            end else if (txn_q == TXN_ID && dec_present) begin
              txn_q <= TXN_QPI;
              st_q  <= ST_GAP;
            end else begin
              st_q <= ST_FIN;
            end
          end
        end
        ST_GAP: begin
          if (gap_q == '0) begin
            cs_n_q <= 1'b0;
            st_q   <= ST_SEL;
          end else begin
            gap_q <= gap_q - 1'b1;
          end
        end
        ST_FIN: begin
          present_q <= dec_present;
          size_q    <= dec_size;
          st_q      <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign cs_no     = cs_n_q;
  assign done_o    = (st_q == ST_FIN);
  assign present_o = done_o ? dec_present : present_q;
  assign size_o    = done_o ? dec_size : size_q;

  // R9
  idle_lines_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> (io_oe_o == 4'h0 && !sck_o));
  // R10
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R5
  absent_size_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !present_o |-> size_o == 4'd0);
  // R6
  size_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(size_o));
  // R11
  busy_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && sh_busy) |=> !cs_no);

endmodule

// File: tb/psram_probe_bench.sv
`timescale 1ns/1ps
module psram_probe_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [7:0] div = 8'd30;
  logic [3:0] io_in = 4'h0;
  logic       sck, cs_n, done, present;
  logic [3:0] io_out, io_oe, size;

  always #5 clk = ~clk;

  psram_probe u_psram_probe (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .clk_div_i(div),
    .io_i(io_in), .sck_o(sck), .cs_no(cs_n), .io_o(io_out), .io_oe_o(io_oe),
    .done_o(done), .present_o(present), .size_o(size)
  );

  int n_chk = 0, n_err = 0;

  task automatic chk(input string req, input bit ok, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural device
  logic [7:0] resp [7];
  bit         dev_qpi = 1'b0;
  int         fr_cnt = 0;
  int         fr_sck [8];
  logic [7:0] fr_quadval [8];
  logic [7:0] fr_data [8][8];
  logic [3:0] fr_oe [8];
  bit         fr_isq [8];

  always @(negedge cs_n) begin
    if (fr_cnt < 8) begin
      fr_sck[fr_cnt] = 0;
      fr_quadval[fr_cnt] = 8'h00;
      fr_oe[fr_cnt] = 4'h0;
      fr_isq[fr_cnt] = dev_qpi;
      for (int k = 0; k < 8; k++) fr_data[fr_cnt][k] = 8'h00;
    end
    io_in = {2'b10, resp[0][7], 1'b1};
  end

  always @(posedge cs_n) begin
    if (fr_cnt < 8) begin
      if (fr_isq[fr_cnt] && fr_sck[fr_cnt] == 2 && fr_quadval[fr_cnt] == 8'hF5) dev_qpi = 1'b0;
      if (!fr_isq[fr_cnt] && fr_sck[fr_cnt] == 8 && fr_data[fr_cnt][0] == 8'h35) dev_qpi = 1'b1;
    end
    fr_cnt++;
  end

  always @(posedge sck) begin
    if (!cs_n && fr_cnt < 8) begin
      int n;
      n = fr_sck[fr_cnt];
      fr_oe[fr_cnt] = fr_oe[fr_cnt] | io_oe;
      if (n < 2) fr_quadval[fr_cnt] = {fr_quadval[fr_cnt][3:0], io_out};
      if (n < 64) fr_data[fr_cnt][n/8] = {fr_data[fr_cnt][n/8][6:0], io_out[0]};
      fr_sck[fr_cnt] = n + 1;
    end
  end

  always @(negedge sck) begin
    if (!cs_n && fr_cnt < 8) begin
      int n;
      n = fr_sck[fr_cnt];
      io_in = {2'b10, (n/8 < 7) ? resp[n/8][7 - n%8] : 1'b0, 1'b1};
    end
  end

  // per-clock monitor
  int  cyc = 0, viol = 0, done_cnt = 0;
  int  last_rise = -1, min_per = 1 << 30, hi_len = 0, hi_min = 1 << 30, hi_max = 0;
  int  cs_rise_t = -1, min_gap = 1 << 30;
  bit  sck_p = 1'b0, cs_p = 1'b1;

  task automatic mon_clear();
    viol = 0; done_cnt = 0; last_rise = -1; min_per = 1 << 30;
    hi_min = 1 << 30; hi_max = 0; cs_rise_t = -1; min_gap = 1 << 30;
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (cs_n && (sck || io_oe != 4'h0)) viol++;
      if (done) done_cnt++;
      if (sck && !sck_p) begin
        if (last_rise >= 0 && cyc - last_rise < min_per) min_per = cyc - last_rise;
        last_rise = cyc;
        hi_len = 0;
      end
      if (sck) hi_len++;
      if (!sck && sck_p) begin
        if (hi_len < hi_min) hi_min = hi_len;
        if (hi_len > hi_max) hi_max = hi_len;
      end
      if (cs_n && !cs_p) cs_rise_t = cyc;
      if (!cs_n && cs_p) begin
        if (cs_rise_t >= 0 && cyc - cs_rise_t < min_gap) min_gap = cyc - cs_rise_t;
        last_rise = -1;
      end
    end
    sck_p = sck;
    cs_p = cs_n;
  end

  task automatic run_probe(input logic [7:0] d, input logic [7:0] kgd, input logic [7:0] eid,
                           input int exp_size, input bit qpi0, input bit poke);
    int ed, t;
    bit exp_p;
    ed = (d == 0) ? 30 : (d == 1) ? 2 : d;
    exp_p = (kgd == 8'h5D);
    div = d;
    for (int k = 0; k < 7; k++) resp[k] = 8'hA0 + 8'(k);
    resp[5] = kgd;
    resp[6] = eid;
    dev_qpi = qpi0;
    fr_cnt = 0;
    mon_clear();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    t = 0;
    while (!done && t < 30000) begin
      @(negedge clk);
      t++;
      if (poke && t == 40) start = 1'b1;
      else start = 1'b0;
    end
    chk("R10 done seen", done, done, 1);
    chk("R5 present", present == exp_p, present, exp_p);
    chk("R6 size", size == exp_size, size, exp_size);
    @(negedge clk);
    chk("R10 done one cycle", !done, done, 0);
    repeat (4) @(negedge clk);
    chk("R10 size held", size == exp_size && present == exp_p, size, exp_size);
    chk("R11 single done", done_cnt == 1, done_cnt, 1);
    chk("R7 frame count", fr_cnt == (exp_p ? 3 : 2), fr_cnt, exp_p ? 3 : 2);
    chk("R2 exit clocks", fr_sck[0] == 2, fr_sck[0], 2);
    chk("R2 exit value", fr_quadval[0] == 8'hF5, fr_quadval[0], 8'hF5);
    chk("R2 exit oe", fr_oe[0] == 4'hF, fr_oe[0], 4'hF);
    chk("R3 id clocks", fr_sck[1] == 56, fr_sck[1], 56);
    chk("R3 id cmd", fr_data[1][0] == 8'h9F, fr_data[1][0], 8'h9F);
    for (int k = 1; k < 7; k++)
      chk("R3 id filler", fr_data[1][k] == 8'hFF, fr_data[1][k], 8'hFF);
    chk("R3 id oe", fr_oe[1] == 4'h1, fr_oe[1], 4'h1);
    if (exp_p) begin
      chk("R7 qpi clocks", fr_sck[2] == 8, fr_sck[2], 8);
      chk("R7 qpi cmd", fr_data[2][0] == 8'h35, fr_data[2][0], 8'h35);
      chk("R7 qpi oe", fr_oe[2] == 4'h1, fr_oe[2], 4'h1);
    end
    chk("R7 device mode", dev_qpi == exp_p, dev_qpi, exp_p);
    chk("R8 period", min_per == ed, min_per, ed);
    chk("R8 high phase", hi_min == ed / 2 && hi_max == ed / 2, hi_max, ed / 2);
    chk("R9 gap", min_gap >= 2 * ed, min_gap, 2 * ed);
    chk("R9 idle lines", viol == 0, viol, 0);
  endtask

  initial begin
    #(200000 * 10);
    n_err++;
    n_chk++;
    $display("FAIL R10 watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    for (int k = 0; k < 7; k++) resp[k] = 8'h00;
    repeat (3) @(negedge clk);
    chk("R1 cs", cs_n == 1'b1, cs_n, 1);
    chk("R1 sck/oe", sck == 1'b0 && io_oe == 4'h0, {sck, io_oe}, 0);
    chk("R1 outputs", done == 0 && present == 0 && size == 0, {done, present, size}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    run_probe(8'd0,  8'h5D, 8'h26, 8, 1'b1, 1'b0);  // R6 special value, R8 default divisor
    run_probe(8'd2,  8'h5D, 8'h40, 8, 1'b0, 1'b0);  // R6 density 2
    run_probe(8'd3,  8'h5D, 8'h1F, 2, 1'b1, 1'b0);  // R6 density 0, odd divisor
    run_probe(8'd5,  8'h5D, 8'h3A, 4, 1'b0, 1'b1);  // R6 density 1, R11 busy start
    run_probe(8'd1,  8'h5D, 8'hE0, 1, 1'b0, 1'b0);  // R6 other, R8 divisor 1
    run_probe(8'd4,  8'h5C, 8'h40, 0, 1'b1, 1'b0);  // R5 bad die, R7 no enable
    run_probe(8'd2,  8'h00, 8'h26, 0, 1'b0, 1'b0);  // R4 R5 absent
    resp[5] = 8'h5D;
    run_probe(8'd6,  8'h5D, 8'h20, 4, 1'b0, 1'b0);  // R4 other bytes ignored
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule